// File: doc/BRIEF.md
# Alarm-Started Periodic Pulse Generator

This block turns a free-running 64-bit time value into timed pulse trains. It holds up to two 64-bit alarm comparators and three pulse channels. When the time value reaches an armed alarm, the comparator raises a single alarm event. Every enabled channel that is waiting on that alarm emits its first pulse and then keeps pulsing at a programmed interval. The time counter itself lives outside the block. It provides both the current time and the integer number of nanoseconds the time advances per clock, and the block uses that tick size to count the interval down.

Each channel has one control byte with four fields: a disable bit, an output gate, an alarm select and a 5-bit pulse width. The width is counted in output-clock cycles, which are reference-clock cycles divided by a prescaler. The interval register holds the wanted period minus one tick. Every pulse and every alarm fire sets a sticky event flag. Software clears a flag by writing 1 to it. A maskable interrupt is the OR of the unmasked flags. Software writes registers over a simple single-cycle write port. An alarm value takes effect only when its high half is written, so a half-written alarm can never match.

Top module: `alarm_pulse_gen`

## Requirements
- R1: After reset, pulse_out is 0, event_flags is 0 and irq is 0. Both alarms hold all ones and all intervals hold all ones. Every channel's disable bit (control bit 8i+7) is set, and the prescaler is 2. A channel enabled without any alarm programming produces no pulse and no event.
- R2: Register addresses are: 0 control, 1 interrupt mask, 2 event flags, 3 prescaler (bits 7:0), 4/5 alarm 0 low/high, 6/7 alarm 1 low/high, 8+i interval of channel i. A write to an alarm's low half only loads a holding register. The alarm's compare value does not change until its high half is written, which loads {high, held low} and re-arms the alarm.
- R3: An armed alarm whose value is at or below cur_time fires in the next clock edge. Firing sets event bit 16+a and disarms the alarm, so it does not fire again until its high half is rewritten.
- R4: Channel i owns control bits [8i+7:8i]: bit 7 disable, bit 6 gate, bit 5 start on alarm 1 (0 means alarm 0), bits 4:0 width.
- R5: When a channel's disable bit is cleared, the channel waits one cycle to arm and then waits for its selected alarm. Its first pulse starts on the same edge on which that alarm fires.
- R6: After a pulse, the channel loads its interval I. On each clock it subtracts tick_ns while the count is at least tick_ns; otherwise it pulses and reloads. With I = (k-1)*tick_ns the pulses come every k cycles.
- R7: A pulse holds pulse_out high for W*P clock cycles, where W is the width field and P is the prescaler value (P=0 counts as 1). W=0 gives no output pulse. A new pulse restarts the width timer.
- R8: With the gate bit set, the channel keeps its timing and still sets its event flag, but its pulse_out stays 0.
- R9: Setting a channel's disable bit forces its pulse_out to 0 from the next edge and stops its pulses.
- R10: A pulse on channel i sets event bit 7-i. Writing 1 to an event bit clears it and writing 0 leaves it set. If a hardware set and a clear land on the same bit in the same cycle, the set wins.
- R11: irq is 1 exactly when some event bit is set and its mask bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_time | input | 64 | Current time from the time counter |
| tick_ns | input | 10 | Integer time advance per clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| pulse_out | output | 3 | Pulse outputs, one per channel |
| event_flags | output | 32 | Sticky event flags |
| irq | output | 1 | Masked OR of the event flags |

## Verification
Two functions can fall on the same edge. The first pair is a software write-1-to-clear of a pulse flag and the hardware pulse that sets that same flag. The bench provokes it by clearing the channel-0 flag on several consecutive cycles while that channel pulses every four cycles, so one of the clears is certain to coincide with a pulse. The second pair is an alarm re-arm and an alarm comparison, which meet when the high half is written with a value already in the past. A behavioural model judges every cycle and expects the set to win over the clear, and the re-armed alarm to fire on the following edge.

// File: rtl/apg_pkg.sv
package apg_pkg;
  localparam int unsigned ADDR_W      = 4;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_MASK   = 1;
  localparam int unsigned ADDR_EVENT  = 2;
  localparam int unsigned ADDR_PRESC  = 3;
  localparam int unsigned ADDR_ALM0   = 4;  // alarm a: low at 4+2a, high at 5+2a
  localparam int unsigned ADDR_IVL0   = 8;  // interval of channel i at 8+i
  localparam int unsigned MAX_ALARMS  = 2;
  localparam int unsigned ALM_EVT_LSB = 16; // alarm a sets bit 16+a
  localparam int unsigned PLS_EVT_MSB = 7;  // channel i sets bit 7-i
  localparam int unsigned WIDTH_W     = 5;

  typedef enum logic [1:0] {
    CH_OFF   = 2'd0,
    CH_ARMED = 2'd1,
    CH_RUN   = 2'd2
  } apg_state_e;
endpackage

// File: rtl/apg_alarm.sv
module apg_alarm #(
  parameter int unsigned TIME_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [TIME_W/2-1:0] wr_data,
  input  logic [TIME_W-1:0]   cur_time,
  output logic                fire
);
  localparam int unsigned HALF_W = TIME_W / 2;

  logic [HALF_W-1:0] hold_q, hold_d;
  logic [TIME_W-1:0] cmp_q, cmp_d;
  logic              armed_q, armed_d;

  assign fire = armed_q && (cur_time >= cmp_q);

  always_comb begin
    hold_d  = hold_q;
    cmp_d   = cmp_q;
    armed_d = armed_q;
    if (fire) armed_d = 1'b0;
    if (wr_lo) hold_d = wr_data;
    if (wr_hi) begin
      cmp_d   = {wr_data, hold_q};
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '1;
      cmp_q   <= '1;
      armed_q <= 1'b1;
    end else begin
      hold_q  <= hold_d;
      cmp_q   <= cmp_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/apg_chan.sv
module apg_chan
  import apg_pkg::*;
#(
  parameter int unsigned IVL_W   = 32,
  parameter int unsigned TICK_W  = 10,
  parameter int unsigned PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dis,
  input  logic               gate,
  input  logic [WIDTH_W-1:0] width,
  input  logic               start,
  input  logic [IVL_W-1:0]   interval,
  input  logic [TICK_W-1:0]  tick,
  input  logic [PRESC_W-1:0] presc,
  output logic               fire,
  output logic               pulse
);
  apg_state_e         st_q, st_d;
  logic [IVL_W-1:0]   cnt_q, cnt_d;
  logic               out_q, out_d;
  logic [WIDTH_W-1:0] wleft_q, wleft_d;
  logic [PRESC_W-1:0] pcnt_q, pcnt_d;
  logic [IVL_W-1:0]   step;
  logic [PRESC_W-1:0] pload;

  assign step  = {{(IVL_W-TICK_W){1'b0}}, tick};
  assign pload = (presc == '0) ? '0 : presc - 1'b1;
  assign pulse = out_q;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    out_d   = out_q;
    wleft_d = wleft_q;
    pcnt_d  = pcnt_q;
    fire    = 1'b0;
    if (dis) begin
      st_d    = CH_OFF;
      out_d   = 1'b0;
      wleft_d = '0;
      pcnt_d  = '0;
    end else begin
      unique case (st_q)
        CH_OFF: st_d = CH_ARMED;
        CH_ARMED: begin
          if (start) begin
            fire  = 1'b1;
            st_d  = CH_RUN;
            cnt_d = interval;
          end
        end
        CH_RUN: begin
          if (cnt_q < step) begin
            fire  = 1'b1;
            cnt_d = interval;
          end else begin
            cnt_d = cnt_q - step;
          end
        end
        default: st_d = CH_OFF;
      endcase
      if (fire) begin
        out_d   = (width != '0) && !gate;
        wleft_d = width;
        pcnt_d  = pload;
      end else if (out_q) begin
        if (pcnt_q == '0) begin
          pcnt_d  = pload;
          wleft_d = wleft_q - 1'b1;
          if (wleft_q == WIDTH_W'(1)) out_d = 1'b0;
        end else begin
          pcnt_d = pcnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CH_OFF;
      cnt_q   <= '0;
      out_q   <= 1'b0;
      wleft_q <= '0;
      pcnt_q  <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      out_q   <= out_d;
      wleft_q <= wleft_d;
      pcnt_q  <= pcnt_d;
    end
  end
endmodule

// File: rtl/alarm_pulse_gen.sv
module alarm_pulse_gen
  import apg_pkg::*;
#(
  parameter int unsigned NUM_CH     = 3,
  parameter int unsigned NUM_ALARMS = 2,
  parameter int unsigned TICK_W     = 10,
  parameter int unsigned PRESC_W    = 8,
  parameter int unsigned PRESC_RST  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [63:0]         cur_time,
  input  logic [TICK_W-1:0]   tick_ns,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  output logic [NUM_CH-1:0]   pulse_out,
  output logic [REG_W-1:0]    event_flags,
  output logic                irq
);
  localparam int unsigned CTRL_W = NUM_CH * 8;
  localparam int unsigned IVL_W  = REG_W;

  function automatic logic [CTRL_W-1:0] ctrl_reset();
    logic [CTRL_W-1:0] v;
    v = '0;
    for (int c = 0; c < NUM_CH; c++) v[8*c+7] = 1'b1;
    return v;
  endfunction

  logic [CTRL_W-1:0]     ctrl_q, ctrl_d;
  logic [REG_W-1:0]      mask_q, mask_d;
  logic [REG_W-1:0]      ev_q, ev_d;
  logic [REG_W-1:0]      ev_clr, ev_set;
  logic [PRESC_W-1:0]    presc_q, presc_d;
  logic [IVL_W-1:0]      ivl_q [NUM_CH];
  logic [IVL_W-1:0]      ivl_d [NUM_CH];
  logic [MAX_ALARMS-1:0] alarm_fire;
  logic [NUM_CH-1:0]     ch_fire;
  logic [NUM_CH-1:0]     ch_dis;

  always_comb begin
    ctrl_d  = ctrl_q;
    mask_d  = mask_q;
    presc_d = presc_q;
    ev_clr  = '0;
    for (int c = 0; c < NUM_CH; c++) ivl_d[c] = ivl_q[c];
    if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_CTRL))  ctrl_d  = wr_data[CTRL_W-1:0];
      if (wr_addr == ADDR_W'(ADDR_MASK))  mask_d  = wr_data;
      if (wr_addr == ADDR_W'(ADDR_EVENT)) ev_clr  = wr_data;
      if (wr_addr == ADDR_W'(ADDR_PRESC)) presc_d = wr_data[PRESC_W-1:0];
      for (int c = 0; c < NUM_CH; c++)
        if (wr_addr == ADDR_W'(ADDR_IVL0 + c)) ivl_d[c] = wr_data;
    end
  end

  always_comb begin
    ev_set = '0;
    for (int a = 0; a < MAX_ALARMS; a++) ev_set[ALM_EVT_LSB+a] = alarm_fire[a];
    for (int c = 0; c < NUM_CH; c++)     ev_set[PLS_EVT_MSB-c] = ch_fire[c];
    ev_d = (ev_q & ~ev_clr) | ev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= ctrl_reset();
      mask_q  <= '0;
      ev_q    <= '0;
      presc_q <= PRESC_W'(PRESC_RST);
      for (int c = 0; c < NUM_CH; c++) ivl_q[c] <= '1;
    end else begin
      ctrl_q  <= ctrl_d;
      mask_q  <= mask_d;
      ev_q    <= ev_d;
      presc_q <= presc_d;
      for (int c = 0; c < NUM_CH; c++) ivl_q[c] <= ivl_d[c];
    end
  end

  for (genvar a = 0; a < MAX_ALARMS; a++) begin : g_alarm
    if (a < NUM_ALARMS) begin : g_on
      apg_alarm #(.TIME_W(64)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo    (wr_en && (wr_addr == ADDR_W'(ADDR_ALM0 + 2*a))),
        .wr_hi    (wr_en && (wr_addr == ADDR_W'(ADDR_ALM0 + 2*a + 1))),
        .wr_data  (wr_data),
        .cur_time (cur_time),
        .fire     (alarm_fire[a])
      );
    end else begin : g_off
      assign alarm_fire[a] = 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic start;
    assign ch_dis[c] = ctrl_q[8*c+7];
    assign start     = ctrl_q[8*c+5] ? alarm_fire[1] : alarm_fire[0];
    apg_chan #(
      .IVL_W   (IVL_W),
      .TICK_W  (TICK_W),
      .PRESC_W (PRESC_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .dis      (ch_dis[c]),
      .gate     (ctrl_q[8*c+6]),
      .width    (ctrl_q[8*c +: WIDTH_W]),
      .start    (start),
      .interval (ivl_q[c]),
      .tick     (tick_ns),
      .presc    (presc_q),
      .fire     (ch_fire[c]),
      .pulse    (pulse_out[c])
    );
  end

  assign event_flags = ev_q;
  assign irq         = |(ev_q & mask_q);
endmodule

// File: rtl/apg_checker.sv
module apg_checker
  import apg_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [REG_W-1:0]      wr_data,
  input logic [NUM_CH-1:0]     pulse_out,
  input logic [REG_W-1:0]      event_flags,
  input logic [NUM_CH-1:0]     chan_dis,
  input logic [MAX_ALARMS-1:0] alarm_fire
);
  logic [REG_W-1:0] keep;
  assign keep = event_flags &
                ~((wr_en && wr_addr == ADDR_W'(ADDR_EVENT)) ? wr_data : '0);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((event_flags & $past(keep)) == $past(keep))); // R10

  for (genvar a = 0; a < MAX_ALARMS; a++) begin : g_a
    AST_ALARM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_fire[a] |=> event_flags[ALM_EVT_LSB+a]); // R3
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    AST_DIS_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      chan_dis[c] |=> !pulse_out[c]); // R9
    AST_RISE_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_out[c]) |-> event_flags[PLS_EVT_MSB-c]); // R10
  end
endmodule

bind alarm_pulse_gen apg_checker #(.NUM_CH(NUM_CH)) u_apg_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .pulse_out   (pulse_out),
  .event_flags (event_flags),
  .chan_dis    (ch_dis),
  .alarm_fire  (alarm_fire)
);

// File: tb/tb_alarm_pulse_gen.sv
`timescale 1ns/1ps
module tb_alarm_pulse_gen;
  localparam int TICK = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] cur_time = '0;
  logic [9:0]  tick_ns = 10'(TICK);
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  pulse_out;
  logic [31:0] event_flags;
  logic        irq;

  int total = 0, bad = 0, wd = 0;
  bit finished = 0;

  alarm_pulse_gen dut (
    .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .tick_ns(tick_ns),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pulse_out(pulse_out), .event_flags(event_flags), .irq(irq)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) if (rst_n) cur_time <= cur_time + 64'(TICK);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [63:0] m_alarm [2];
  logic [31:0] m_hold [2];
  bit          m_armed [2];
  logic [23:0] m_ctrl;
  logic [31:0] m_mask, m_ev;
  logic [7:0]  m_presc;
  logic [31:0] m_ivl [3];
  int          m_st [3];
  logic [31:0] m_cnt [3];
  logic [2:0]  m_out;
  int          m_wl [3];
  int          m_pc [3];

  always @(posedge clk) begin
    bit hit [2];
    logic [31:0] setv, clrv;
    logic [7:0] b;
    bit fire;
    int pl;
    if (!rst_n) begin
      for (int a = 0; a < 2; a++) begin m_alarm[a] = '1; m_hold[a] = '1; m_armed[a] = 1; end
      m_ctrl = 24'h808080; m_mask = 0; m_ev = 0; m_presc = 2; m_out = 0;
      for (int c = 0; c < 3; c++) begin m_ivl[c] = '1; m_st[c] = 0; m_cnt[c] = 0; m_wl[c] = 0; m_pc[c] = 0; end
    end else begin
      setv = 0;
      for (int a = 0; a < 2; a++) begin
        hit[a] = m_armed[a] && (cur_time >= m_alarm[a]);
        if (hit[a]) setv[16+a] = 1'b1;
      end
      pl = (m_presc == 0) ? 0 : int'(m_presc) - 1;
      for (int c = 0; c < 3; c++) begin
        b = m_ctrl[8*c +: 8];
        fire = 0;
        if (b[7]) begin
          m_st[c] = 0; m_out[c] = 0; m_wl[c] = 0; m_pc[c] = 0;
        end else begin
          if (m_st[c] == 0) m_st[c] = 1;
          else if (m_st[c] == 1) begin
            if (hit[b[5]]) begin fire = 1; m_st[c] = 2; m_cnt[c] = m_ivl[c]; end
          end else begin
            if (m_cnt[c] < 32'(TICK)) begin fire = 1; m_cnt[c] = m_ivl[c]; end
            else m_cnt[c] = m_cnt[c] - 32'(TICK);
          end
          if (fire) begin
            m_out[c] = (b[4:0] != 0) && !b[6]; m_wl[c] = int'(b[4:0]); m_pc[c] = pl;
            setv[7-c] = 1'b1;
          end else if (m_out[c]) begin
            if (m_pc[c] == 0) begin
              m_pc[c] = pl;
              if (m_wl[c] == 1) m_out[c] = 0;
              m_wl[c] = m_wl[c] - 1;
            end else m_pc[c] = m_pc[c] - 1;
          end
        end
      end
      clrv = (wr_en && wr_addr == 2) ? wr_data : 0;
      m_ev = (m_ev & ~clrv) | setv;
      for (int a = 0; a < 2; a++) if (hit[a]) m_armed[a] = 0;
      if (wr_en) begin
        case (wr_addr)
          0: m_ctrl = wr_data[23:0];
          1: m_mask = wr_data;
          3: m_presc = wr_data[7:0];
          4: m_hold[0] = wr_data;
          5: begin m_alarm[0] = {wr_data, m_hold[0]}; m_armed[0] = 1; end
          6: m_hold[1] = wr_data;
          7: begin m_alarm[1] = {wr_data, m_hold[1]}; m_armed[1] = 1; end
          8, 9, 10: m_ivl[wr_addr-8] = wr_data;
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(pulse_out == m_out, "R6 pulse_out vs model", 64'(pulse_out), 64'(m_out));
      chk(event_flags == m_ev, "R10 event_flags vs model", 64'(event_flags), 64'(m_ev));
      chk(irq == |(m_ev & m_mask), "R11 irq vs model", 64'(irq), 64'(|(m_ev & m_mask)));
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", wd, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(input int ch, input int n, output int rises, output int highs);
    logic prev;
    prev = pulse_out[ch]; rises = 0; highs = 0;
    repeat (n) begin
      @(negedge clk);
      if (pulse_out[ch]) highs++;
      if (pulse_out[ch] && !prev) rises++;
      prev = pulse_out[ch];
    end
  endtask

  initial begin
    int r, h;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk(pulse_out == 0, "R1 reset pulse_out", 64'(pulse_out), 0);
    chk(event_flags == 0, "R1 reset event_flags", 64'(event_flags), 0);
    chk(irq == 0, "R1 reset irq", 64'(irq), 0);

    wr(0, 32'h0080_8001);            // ch0 enabled, alarm 0, width 1
    wr(8, 32'd24);                   // period 4 cycles
    cyc(50);
    chk(event_flags == 0 && pulse_out == 0, "R1 no start with idle alarm", 64'(event_flags), 0);

    wr(4, 32'd2000);                 // low half only
    cyc(300);
    chk(event_flags[16] == 0, "R2 low half alone does not arm", 64'(event_flags[16]), 0);

    wr(5, 32'd0);                    // commit, already in the past
    cyc(2);
    chk(event_flags[16] == 1, "R3 alarm 0 fired", 64'(event_flags[16]), 1);
    chk(event_flags[7] == 1, "R5 channel 0 started on alarm", 64'(event_flags[7]), 1);

    watch(0, 40, r, h);
    chk(r == 10, "R6 channel 0 pulse count", 64'(r), 10);
    chk(h == 20, "R7 channel 0 high cycles", 64'(h), 20);

    wr(2, 32'h0001_0000);
    cyc(20);
    chk(event_flags[16] == 0, "R3 alarm does not refire", 64'(event_flags[16]), 0);

    wr(2, 32'h0);
    chk(event_flags[7] == 1, "R10 writing zero keeps flag", 64'(event_flags[7]), 1);

    wr(9, 32'd56);
    wr(10, 32'd120);
    wr(0, 32'h0025_6301);            // ch1 gated alarm1 w3, ch2 alarm1 w5
    wr(6, cur_time[31:0] + 32'd400);
    wr(7, cur_time[63:32]);
    cyc(70);
    chk(event_flags[6] == 1 && event_flags[5] == 1, "R4 channels 1,2 follow alarm 1",
        64'(event_flags[6:5]), 3);
    chk(event_flags[17] == 1, "R3 alarm 1 fired", 64'(event_flags[17]), 1);

    watch(1, 40, r, h);
    chk(h == 0, "R8 gated channel stays low", 64'(h), 0);

    watch(2, 32, r, h);
    chk(h == 20, "R7 width 5 prescaler 2", 64'(h), 20);
    wr(3, 32'd0);
    cyc(20);
    watch(2, 32, r, h);
    chk(h == 10, "R7 prescaler 0 acts as 1", 64'(h), 10);

    // clear collides with a pulse on channel 0 (model judges every cycle)
    for (int k = 0; k < 5; k++) wr(2, 32'h0000_0080);
    cyc(2);
    chk(event_flags[7] == 1, "R10 flag set again after clears", 64'(event_flags[7]), 1);

    wr(1, 32'h0000_0020);
    wr(2, 32'hFFFF_FFFF);
    cyc(20);
    chk(irq == 1, "R11 unmasked flag raises irq", 64'(irq), 1);
    wr(1, 32'h0);
    chk(irq == 0, "R11 mask cleared drops irq", 64'(irq), 0);

    wr(0, 32'h00A5_6301);            // disable channel 2
    cyc(1);
    chk(pulse_out[2] == 0, "R9 disabled output low", 64'(pulse_out[2]), 0);
    watch(2, 40, r, h);
    chk(r == 0, "R9 no pulses while disabled", 64'(r), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule